// File: doc/BRIEF.md
# Nine-bit multiprocessor serial port

This block is a serial port in the classic microcontroller style. It has four framings: a clocked shift register, an 8-bit asynchronous frame, and two 9-bit asynchronous frames. In the 9-bit frames the extra bit can mark address frames, so several receivers can share one line. One 8-bit control/status register sets the framing, the receive enable, the ninth transmit bit and the address-filter option. The same register holds the ninth received bit and the two event flags. A second location holds the data: a write there starts a transmission, and a read returns the last accepted received byte.

The filter bit in the control register changes its meaning with the framing. In the 8-bit asynchronous framing it makes a frame with a low stop bit count as invalid. In the 9-bit framings it accepts only frames whose ninth bit is high. In the shift-register framing it has no effect. Bit timing comes from outside. For the 8-bit framing and the variable-rate 9-bit framing, an external pulse at sixteen times the bit rate sets the timing. The fixed-rate 9-bit framing divides the system clock instead. The shift-register framing runs at one twelfth of the system clock.

Top module: `uart9_port`

## Requirements
- R1: After reset, the control register reads 00h, txd_o is 1, irq_o is 0 and m0_clk_o is 0.
- R2: The control register bits are, from bit 7 down to bit 0: mode high, mode low, filter, receive enable, TB8, RB8, TI, RI. A write at reg_addr 0 stores all eight bits, and a read returns them. The mode is {bit7,bit6}: 00 is the shift register, 01 is 8-bit asynchronous, 10 is 9-bit fixed rate, 11 is 9-bit variable rate.
- R3: In mode 1, a write at reg_addr 1 sends a start bit (0), eight data bits LSB first, then a stop bit (1) on txd_o. TI sets at the start of the stop bit.
- R4: In modes 2 and 3, TB8 is sent as a ninth bit between the data bits and the stop bit.
- R5: A bit lasts 16 baud_tick pulses in modes 1 and 3, and 16×M2_TICK_DIV clocks in mode 2, whatever baud_tick does.
- R6: In mode 1 with the filter bit clear, a received frame loads the data buffer, copies the stop-bit level into RB8 and sets RI.
- R7: In mode 1 with the filter bit set, a frame whose stop bit is 0 leaves RI and the buffer unchanged. With the filter bit clear, the same frame is accepted with RB8 = 0.
- R8: In modes 2 and 3, RB8 takes the ninth received bit. With the filter bit set, only frames whose ninth bit is 1 are accepted. With it clear, every frame is accepted.
- R9: With receive enable clear, no frame is received.
- R10: A frame that ends while RI is 1 is discarded, and the buffer keeps its old value.
- R11: A low pulse on rxd_i shorter than half a bit is rejected as a false start. A valid frame that follows is received correctly.
- R12: In mode 0, a write at reg_addr 1 shifts eight bits out LSB first on m0_data_o, with m0_data_oe high. Each bit is sampled on a rising edge of m0_clk_o, whose period is M0_DIV clocks. TI sets after the eighth bit.
- R13: In mode 0, reception runs while receive enable is 1 and RI is 0. It clocks eight bits LSB first from rxd_i on the rising edges of m0_clk_o. The filter bit has no effect.
- R14: irq_o is TI OR RI. The hardware only sets TI and RI, and they clear only through a host write of the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control register, 1 = data buffer |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| baud_tick | input | 1 | 16x oversample pulse for modes 1 and 3 |
| rxd_i | input | 1 | Serial receive line (data input in mode 0) |
| txd_o | output | 1 | Asynchronous transmit line, idles at 1 |
| m0_data_o | output | 1 | Mode 0 transmit data |
| m0_data_oe | output | 1 | Mode 0 transmit data enable |
| m0_clk_o | output | 1 | Mode 0 shift clock |
| irq_o | output | 1 | Combined interrupt, TI or RI |

## Verification
The assertions assume the host does not change the mode while a frame is moving. They also assume that in mode 0 the host does not start a transmission while a reception is running. The bench switches the mode only while the line is idle, and it clears receive enable before any mode-0 transmission. The assertions further assume that RI rises only through an accepted frame or a host write. The stimulus never changes receive enable in the middle of a frame, so an enable change never collides with a frame's completion.

// File: rtl/uart9_pkg.sv
// Shared types for the nine-bit serial port.
// Assumes: control register layout is fixed by the bit order below.
package uart9_pkg;
    typedef enum logic [1:0] {
        MODE_SHIFT = 2'b00,
        MODE_ASYNC8 = 2'b01,
        MODE_FIXED9 = 2'b10,
        MODE_VAR9 = 2'b11
    } mode_e;

    typedef struct packed {
        logic [1:0] mode;
        logic       filt;
        logic       ren;
        logic       tb8;
        logic       rb8;
        logic       ti;
        logic       ri;
    } ctl_t;

    localparam logic ADDR_CTL = 1'b0;
    localparam logic ADDR_BUF = 1'b1;
endpackage

// File: rtl/uart9_regs.sv
// Control/status register and receive buffer.
// Assumes: hardware flag sets win over a host write in the same cycle.
module uart9_regs
    import uart9_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic       reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       ti_set,
    input  logic       rx_load,
    input  logic       rb8_we,
    input  logic [7:0] rx_data,
    input  logic       rx_bit9,
    output ctl_t       ctl_q
);
    logic [7:0] rbuf_q;

    // Register updates: host writes first, hardware events override.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            rbuf_q <= '0;
        end else begin
            if (reg_we && reg_addr == ADDR_CTL) ctl_q <= ctl_t'(reg_wdata);
            if (ti_set) ctl_q.ti <= 1'b1;
            if (rx_load) begin
                ctl_q.ri <= 1'b1;
                rbuf_q   <= rx_data;
            end
            if (rb8_we) ctl_q.rb8 <= rx_bit9;
        end
    end

    // Read mux.
    always_comb begin
        reg_rdata = (reg_addr == ADDR_BUF) ? rbuf_q : ctl_q;
    end
endmodule

// File: rtl/uart9_async_tx.sv
// Asynchronous transmitter for 10- and 11-bit frames.
// Assumes: os_tick is a one-cycle pulse at 16x the bit rate; starts while busy are ignored.
module uart9_async_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic       start,
    input  logic [7:0] data,
    input  logic       nine,
    input  logic       tb8,
    output logic       txd,
    output logic       busy,
    output logic       ti_set
);
    localparam int FW = 11;
    logic [FW-1:0] sh_q;
    logic [3:0]    tcnt_q;
    logic [3:0]    bitn_q;
    logic [3:0]    last_q;
    logic          bit_end;

    always_comb bit_end = busy && os_tick && tcnt_q == 4'd15;

    // Frame shifter and bit timing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '1;
            tcnt_q <= '0;
            bitn_q <= '0;
            last_q <= '0;
            busy   <= 1'b0;
        end else if (start && !busy) begin
            sh_q   <= nine ? {1'b1, tb8, data, 1'b0} : {2'b11, data, 1'b0};
            last_q <= nine ? 4'd10 : 4'd9;
            tcnt_q <= '0;
            bitn_q <= '0;
            busy   <= 1'b1;
        end else if (busy && os_tick) begin
            tcnt_q <= tcnt_q + 4'd1;
            if (tcnt_q == 4'd15) begin
                if (bitn_q == last_q) begin
                    busy <= 1'b0;
                end else begin
                    sh_q   <= {1'b1, sh_q[FW-1:1]};
                    bitn_q <= bitn_q + 4'd1;
                end
            end
        end
    end

    // Line level and TI at the entry to the stop bit.
    always_comb begin
        txd    = busy ? sh_q[0] : 1'b1;
        ti_set = bit_end && (bitn_q + 4'd1 == last_q);
    end
endmodule

// File: rtl/uart9_async_rx.sv
// Asynchronous receiver with 3-sample majority and frame qualification.
// Assumes: os_tick at 16x the bit rate; rxd is asynchronous and is synchronized here.
module uart9_async_rx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic       en,
    input  logic       nine,
    input  logic       filt,
    input  logic       ri,
    input  logic       rxd,
    output logic       load,
    output logic [7:0] data,
    output logic       bit9
);
    logic [2:0] sync_q;
    logic       busy_q;
    logic [3:0] tcnt_q;
    logic [3:0] bitn_q;
    logic [1:0] vote_q;
    logic       b9_q;
    logic       bitv;
    logic       mid;
    logic [3:0] last;
    logic       accept;

    // Input synchronizer plus previous-sample stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 3'b111;
        else        sync_q <= {sync_q[1:0], rxd};
    end

    // Majority vote and decision point.
    always_comb begin
        bitv   = (vote_q[1] & vote_q[0]) | (vote_q[1] & sync_q[1]) | (vote_q[0] & sync_q[1]);
        mid    = busy_q && os_tick && tcnt_q == 4'd9;
        last   = nine ? 4'd10 : 4'd9;
        accept = nine ? (!filt || b9_q) : (!filt || bitv);
        load   = mid && en && bitn_q == last && accept && !ri;
        bit9   = nine ? b9_q : bitv;
    end

    // Frame state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            tcnt_q <= '0;
            bitn_q <= '0;
            vote_q <= '0;
            b9_q   <= 1'b0;
            data   <= '0;
        end else if (!busy_q) begin
            if (en && sync_q[2] && !sync_q[1]) begin
                busy_q <= 1'b1;
                tcnt_q <= '0;
                bitn_q <= '0;
            end
        end else if (!en) begin
            busy_q <= 1'b0;
        end else if (os_tick) begin
            tcnt_q <= tcnt_q + 4'd1;
            if (tcnt_q >= 4'd7 && tcnt_q <= 4'd8) vote_q <= {vote_q[0], sync_q[1]};
            if (tcnt_q == 4'd15) bitn_q <= bitn_q + 4'd1;
            if (tcnt_q == 4'd9) begin
                if (bitn_q == 4'd0) begin
                    if (bitv) busy_q <= 1'b0;
                end else if (bitn_q <= 4'd8) begin
                    data <= {bitv, data[7:1]};
                end else if (nine && bitn_q == 4'd9) begin
                    b9_q <= bitv;
                end
                if (bitn_q == last) busy_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/uart9_shift0.sv
// Mode-0 synchronous shift engine: 8 bits LSB first with a divided shift clock.
// Assumes: transmit and receive do not overlap; transmit has priority at idle.
module uart9_shift0 #(
    parameter int M0_DIV = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       act,
    input  logic       start_tx,
    input  logic [7:0] tx_data,
    input  logic       ren,
    input  logic       ri,
    input  logic       rxd,
    output logic       data_o,
    output logic       data_oe,
    output logic       sclk,
    output logic       ti_set,
    output logic       load,
    output logic [7:0] rx_data
);
    localparam int CW   = (M0_DIV > 2) ? $clog2(M0_DIV) : 1;
    localparam int HALF = M0_DIV / 2;

    logic [CW-1:0] cnt_q;
    logic [2:0]    bitn_q;
    logic [7:0]    sh_q;
    logic          busy_q;
    logic          dir_tx_q;
    logic [1:0]    sync_q;
    logic          fin;

    // Data input synchronizer.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rxd};
    end

    always_comb begin
        fin     = busy_q && cnt_q == CW'(M0_DIV - 1) && bitn_q == 3'd7;
        sclk    = busy_q && cnt_q >= CW'(HALF);
        data_o  = sh_q[0];
        data_oe = busy_q && dir_tx_q;
        ti_set  = fin && dir_tx_q;
        load    = fin && !dir_tx_q && ren && !ri;
        rx_data = sh_q;
    end

    // Shift sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            bitn_q   <= '0;
            sh_q     <= '0;
            busy_q   <= 1'b0;
            dir_tx_q <= 1'b0;
        end else if (!busy_q) begin
            cnt_q  <= '0;
            bitn_q <= '0;
            if (act && start_tx) begin
                busy_q   <= 1'b1;
                dir_tx_q <= 1'b1;
                sh_q     <= tx_data;
            end else if (act && ren && !ri) begin
                busy_q   <= 1'b1;
                dir_tx_q <= 1'b0;
            end
        end else if (!act || (!dir_tx_q && !ren)) begin
            busy_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
            if (!dir_tx_q && cnt_q == CW'(HALF - 1)) sh_q <= {sync_q[1], sh_q[7:1]};
            if (cnt_q == CW'(M0_DIV - 1)) begin
                cnt_q <= '0;
                if (dir_tx_q) sh_q <= {1'b0, sh_q[7:1]};
                if (bitn_q == 3'd7) busy_q <= 1'b0;
                else                bitn_q <= bitn_q + 3'd1;
            end
        end
    end
endmodule

// File: rtl/uart9_port.sv
// Top of the nine-bit multiprocessor serial port: tick selection and engine wiring.
// Assumes: baud_tick is a one-cycle pulse at 16x the bit rate of modes 1 and 3.
module uart9_port
    import uart9_pkg::*;
#(
    parameter int M2_TICK_DIV = 4,
    parameter int M0_DIV      = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic       reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       baud_tick,
    input  logic       rxd_i,
    output logic       txd_o,
    output logic       m0_data_o,
    output logic       m0_data_oe,
    output logic       m0_clk_o,
    output logic       irq_o
);
    localparam int M2W = (M2_TICK_DIV > 2) ? $clog2(M2_TICK_DIV) : 1;

    ctl_t          ctl_q;
    mode_e         mode;
    logic [M2W-1:0] m2cnt_q;
    logic          os_tick;
    logic          wr_buf;
    logic          atx_busy, atx_ti, s0_ti;
    logic          arx_load, s0_load, rx_load;
    logic [7:0]    arx_data, s0_data, rx_data;
    logic          arx_bit9;

    always_comb begin
        mode   = mode_e'(ctl_q.mode);
        wr_buf = reg_we && reg_addr == ADDR_BUF;
    end

    // Fixed divider for mode 2 oversampling.
    always_ff @(posedge clk) begin
        if (!rst_n || mode != MODE_FIXED9)         m2cnt_q <= '0;
        else if (m2cnt_q == M2W'(M2_TICK_DIV - 1)) m2cnt_q <= '0;
        else                                       m2cnt_q <= m2cnt_q + M2W'(1);
    end

    // Oversample tick source per mode.
    always_comb begin
        case (mode)
            MODE_FIXED9: os_tick = (m2cnt_q == M2W'(M2_TICK_DIV - 1));
            MODE_ASYNC8, MODE_VAR9: os_tick = baud_tick;
            default: os_tick = 1'b0;
        endcase
    end

    uart9_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ti_set(atx_ti | s0_ti), .rx_load(rx_load), .rb8_we(arx_load),
        .rx_data(rx_data), .rx_bit9(arx_bit9), .ctl_q(ctl_q)
    );

    uart9_async_tx u_atx (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick),
        .start(wr_buf && mode != MODE_SHIFT), .data(reg_wdata),
        .nine(ctl_q.mode[1]), .tb8(ctl_q.tb8),
        .txd(txd_o), .busy(atx_busy), .ti_set(atx_ti)
    );

    uart9_async_rx u_arx (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick),
        .en(ctl_q.ren && mode != MODE_SHIFT), .nine(ctl_q.mode[1]),
        .filt(ctl_q.filt), .ri(ctl_q.ri), .rxd(rxd_i),
        .load(arx_load), .data(arx_data), .bit9(arx_bit9)
    );

    uart9_shift0 #(.M0_DIV(M0_DIV)) u_s0 (
        .clk(clk), .rst_n(rst_n), .act(mode == MODE_SHIFT),
        .start_tx(wr_buf), .tx_data(reg_wdata), .ren(ctl_q.ren), .ri(ctl_q.ri),
        .rxd(rxd_i), .data_o(m0_data_o), .data_oe(m0_data_oe), .sclk(m0_clk_o),
        .ti_set(s0_ti), .load(s0_load), .rx_data(s0_data)
    );

    // Receive source merge and interrupt.
    always_comb begin
        rx_load = arx_load | s0_load;
        rx_data = (mode == MODE_SHIFT) ? s0_data : arx_data;
        irq_o   = ctl_q.ti | ctl_q.ri;
    end
endmodule

// File: rtl/uart9_port_chk.sv
// Property checker for uart9_port, attached by bind.
// Assumes: mode is not changed mid-frame and REN is not dropped mid-frame.
module uart9_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_we,
    input logic       reg_addr,
    input logic [7:0] ctl,
    input logic       txd_o,
    input logic       atx_busy,
    input logic       rx_load,
    input logic       m0_clk_o
);
    // R14
    ri_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl[0]) |-> $past(reg_we && reg_addr == 1'b0));

    // R14
    ti_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl[1]) |-> $past(reg_we && reg_addr == 1'b0));

    // R10
    rx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_load |-> !ctl[0]);

    // R9
    ri_needs_ren_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ctl[0]) && !$past(reg_we && reg_addr == 1'b0)) |-> $past(ctl[4]));

    // R3
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !atx_busy |-> txd_o);

    // R12
    m0_clk_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m0_clk_o |-> $past(ctl[7:6] == 2'b00));
endmodule

bind uart9_port uart9_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .ctl(ctl_q), .txd_o(txd_o), .atx_busy(atx_busy),
    .rx_load(rx_load), .m0_clk_o(m0_clk_o)
);

// File: tb/sim_uart9_port.sv
// Directed bench for uart9_port: one task per scenario.
module sim_uart9_port;
    localparam int CLK_NS = 10;
    localparam int BIT13  = 32;  // baud_tick every 2 clocks -> 16 ticks
    localparam int BIT2   = 64;  // 16 * M2_TICK_DIV(4)

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       baud_tick = 1'b0;
    logic       rxd_i = 1'b1;
    logic       txd_o, m0_data_o, m0_data_oe, m0_clk_o, irq_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    uart9_port u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .baud_tick(baud_tick),
        .rxd_i(rxd_i), .txd_o(txd_o), .m0_data_o(m0_data_o),
        .m0_data_oe(m0_data_oe), .m0_clk_o(m0_clk_o), .irq_o(irq_o)
    );

    always #(CLK_NS/2) clk = ~clk;

    // Baud pulse every second clock, driven away from the active edge.
    always @(negedge clk) begin
        cycles++;
        baud_tick <= ~baud_tick;
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input int n, input logic [10:0] f, input int per);
        for (int i = 0; i < n; i++) begin
            rxd_i = f[i];
            repeat (per) @(negedge clk);
        end
        rxd_i = 1'b1;
        repeat (per) @(negedge clk);
    endtask

    task automatic capture(input int n, input int per, output logic [10:0] v, output logic pre);
        v = '0; pre = 1'b0;
        while (txd_o !== 1'b0) @(negedge clk);
        repeat (per/2) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            v[i] = txd_o;
            if (i == n-2) pre = irq_o;
            if (i < n-1) repeat (per) @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(1'b0, d);
        chk("R1", "ctl after reset", d, 8'h00);
        chk("R1", "txd idle", txd_o, 1'b1);
        chk("R1", "irq idle", irq_o, 1'b0);
        chk("R1", "m0_clk idle", m0_clk_o, 1'b0);
    endtask

    task automatic t_ctl();
        logic [7:0] d;
        wr(1'b0, 8'hF3);
        rd(1'b0, d);
        chk("R2", "ctl readback", d, 8'hF3);
        chk("R14", "irq with flags", irq_o, 1'b1);
        wr(1'b0, 8'h00);
        rd(1'b0, d);
        chk("R2", "ctl cleared", d, 8'h00);
        chk("R14", "irq cleared", irq_o, 1'b0);
    endtask

    task automatic t_tx_m1();
        logic [10:0] v; logic pre; logic [7:0] d;
        wr(1'b0, 8'h48);  // mode 1, TB8 set but unused
        wr(1'b1, 8'hA5);
        capture(10, BIT13, v, pre);
        chk("R3", "mode1 frame", v[9:0], {1'b1, 8'hA5, 1'b0});
        chk("R3", "TI before stop", pre, 1'b0);
        rd(1'b0, d);
        chk("R3", "TI at stop", d[1], 1'b1);
        idle(100);
        rd(1'b0, d);
        chk("R14", "TI holds", d[1], 1'b1);
        wr(1'b0, 8'h40);
        idle(BIT13);
    endtask

    task automatic t_tx_m23();
        logic [10:0] v; logic pre; logic [7:0] d;
        wr(1'b0, 8'hC8);  // mode 3, TB8=1
        wr(1'b1, 8'h3C);
        capture(11, BIT13, v, pre);
        chk("R4", "mode3 frame", v, {2'b11, 8'h3C, 1'b0});
        idle(BIT13);
        wr(1'b0, 8'h80);  // mode 2, TB8=0
        wr(1'b1, 8'h81);
        capture(11, BIT2, v, pre);
        chk("R5", "mode2 fixed-rate frame", v, {2'b10, 8'h81, 1'b0});
        chk("R4", "TI before stop", pre, 1'b0);
        rd(1'b0, d);
        chk("R4", "TI set", d[1], 1'b1);
        idle(BIT2);
        wr(1'b0, 8'h00);
    endtask

    task automatic t_rx_m1();
        logic [7:0] d;
        wr(1'b0, 8'h50);
        send(10, {1'b1, 8'h96, 1'b0}, BIT13);
        rd(1'b1, d); chk("R6", "buffer", d, 8'h96);
        rd(1'b0, d); chk("R6", "RI/RB8", {d[2], d[0]}, 2'b11);
        idle(60);
        rd(1'b0, d); chk("R14", "RI holds", d[0], 1'b1);
        wr(1'b0, 8'h70);  // filter on
        send(10, {1'b0, 8'h11, 1'b0}, BIT13);
        rd(1'b0, d); chk("R7", "bad stop no RI", d[0], 1'b0);
        rd(1'b1, d); chk("R7", "buffer kept", d, 8'h96);
        wr(1'b0, 8'h50);  // filter off
        send(10, {1'b0, 8'h22, 1'b0}, BIT13);
        rd(1'b1, d); chk("R7", "bad stop accepted", d, 8'h22);
        rd(1'b0, d); chk("R7", "RI/RB8", {d[2], d[0]}, 2'b01);
        wr(1'b0, 8'h00);
    endtask

    task automatic t_rx_m3();
        logic [7:0] d;
        wr(1'b0, 8'hF0);  // mode 3, filter, REN
        send(11, {2'b10, 8'h33, 1'b0}, BIT13);
        rd(1'b0, d); chk("R8", "data frame filtered", d[0], 1'b0);
        send(11, {2'b11, 8'h44, 1'b0}, BIT13);
        rd(1'b1, d); chk("R8", "address frame", d, 8'h44);
        rd(1'b0, d); chk("R8", "RI/RB8 address", {d[2], d[0]}, 2'b11);
        wr(1'b0, 8'hD0);  // filter off
        send(11, {2'b10, 8'h55, 1'b0}, BIT13);
        rd(1'b1, d); chk("R8", "unfiltered frame", d, 8'h55);
        rd(1'b0, d); chk("R8", "RI/RB8 data", {d[2], d[0]}, 2'b01);
        wr(1'b0, 8'h40);  // REN off
        send(10, {1'b1, 8'h77, 1'b0}, BIT13);
        rd(1'b0, d); chk("R9", "no RI without REN", d[0], 1'b0);
        rd(1'b1, d); chk("R9", "buffer kept", d, 8'h55);
        wr(1'b0, 8'h51);  // REN with RI already set
        send(10, {1'b1, 8'h88, 1'b0}, BIT13);
        rd(1'b1, d); chk("R10", "overrun discarded", d, 8'h55);
        rd(1'b0, d); chk("R10", "RI still set", d[0], 1'b1);
        wr(1'b0, 8'h50);
        rxd_i = 1'b0; idle(6); rxd_i = 1'b1; idle(BIT13 * 2);
        rd(1'b0, d); chk("R11", "glitch rejected", d[0], 1'b0);
        send(10, {1'b1, 8'h5A, 1'b0}, BIT13);
        rd(1'b1, d); chk("R11", "frame after glitch", d, 8'h5A);
        wr(1'b0, 8'h00);
    endtask

    task automatic t_m0_tx();
        logic [7:0] v; logic [7:0] d; int gap; int per; logic oe;
        v = '0; per = 0; oe = 1'b1;
        wr(1'b0, 8'h00);
        wr(1'b1, 8'hC5);
        for (int i = 0; i < 8; i++) begin
            gap = 0;
            while (!(m0_clk_o === 1'b1)) begin @(negedge clk); gap++; end
            v[i] = m0_data_o;
            oe = oe & m0_data_oe;
            while (m0_clk_o === 1'b1) begin @(negedge clk); gap++; end
            if (i == 1) per = gap;
        end
        chk("R12", "shifted byte", v, 8'hC5);
        chk("R12", "shift clock period", per, 12);
        chk("R12", "data enable", oe, 1'b1);
        idle(4);
        rd(1'b0, d); chk("R12", "TI after 8 bits", d[1], 1'b1);
        wr(1'b0, 8'h00);
    endtask

    task automatic t_m0_rx();
        logic [7:0] pat; logic [7:0] d;
        pat = 8'h6B;
        wr(1'b0, 8'h20);  // mode 0, filter set (no effect)
        rxd_i = pat[0];
        wr(1'b0, 8'h30);  // REN
        for (int i = 1; i < 9; i++) begin
            while (m0_clk_o !== 1'b1) @(negedge clk);
            if (i < 8) rxd_i = pat[i];
            while (m0_clk_o === 1'b1) @(negedge clk);
        end
        idle(4);
        rxd_i = 1'b1;
        rd(1'b0, d); chk("R13", "RI in mode 0", d[0], 1'b1);
        rd(1'b1, d); chk("R13", "received byte", d, pat);
        idle(30);
        chk("R13", "stopped while RI set", m0_clk_o, 1'b0);
        wr(1'b0, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctl();
        t_tx_m1();
        t_tx_m23();
        t_rx_m1();
        t_rx_m3();
        t_m0_tx();
        t_m0_rx();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog.
    initial begin
        wait (cycles > 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule